// File: doc/BRIEF.md
# Eight-Bit Accumulator Arithmetic/Logic Unit

This block is the arithmetic and logic stage of a small 8-bit controller datapath. Each cycle in which `op_valid` is high, it takes an operation code from the instruction decoder and one or two 8-bit operands. At the next clock edge it registers an 8-bit primary result and, for multiply and divide, an 8-bit secondary result. The carry, auxiliary-carry and overflow flags live inside the block. Carry-using operations (add with carry, subtract with borrow, decimal adjust, rotates through carry) read the stored carry. Every flag-writing operation updates these flags in the same edge that writes the result.

The operation set covers the arithmetic group, the logic group and the rotate group. The arithmetic group is add, add with carry, subtract with borrow, increment, decrement, compare, 8x8 multiply, 8/8 divide and decimal adjust after a BCD add. The logic group is AND, OR, XOR and complement. The rotate group is left and right rotates, rotates through carry, and a nibble swap. Parity always reflects the registered primary result. The block has no instruction fetch, register file or bit addressing: operands come from outside, and the primary result is the accumulator value the surrounding datapath writes back.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high `rst` clears both results and the carry, auxiliary-carry and overflow flags to zero.
- R2: Results and flags change only at a clock edge where `op_valid` is high, one cycle after the operands are presented. An `op_sel` value from 18 to 31 changes nothing.
- R3: Add (code 0) forms a+b, and add with carry (code 1) forms a+b+carry. Both write the low 8 bits, set carry from bit 7, set auxiliary carry from bit 3 and set overflow on two's-complement overflow.
- R4: Subtract with borrow (code 2) forms a-b-carry. Carry is set on a borrow out of bit 7, auxiliary carry on a borrow out of bit 3, and overflow on signed overflow.
- R5: Increment (code 3) writes a+1 and decrement (code 4) writes a-1, both wrapping modulo 256. All three flags stay unchanged.
- R6: Compare (code 5) sets carry when a is below b as unsigned numbers. It writes neither result and leaves auxiliary carry and overflow unchanged.
- R7: Multiply (code 8'h? none, code 6) writes the low byte of the 16-bit product a*b to the primary result and the high byte to the secondary result. It sets overflow when the high byte is nonzero and clears carry.
- R8: Divide (code 7) with a nonzero b writes the quotient a/b to the primary result and the remainder to the secondary result. It clears carry and overflow.
- R9: Divide by zero sets overflow and clears carry. It writes 8'hFF to the primary result and a to the secondary result.
- R10: Decimal adjust (code 8) acts on a. It adds 6 when the low nibble exceeds 9 or auxiliary carry is set. It then adds 8'h60 when the high nibble of that sum exceeds 9, when carry is set, or when the first step carried out. Carry is set if either step carries out of bit 7 and is never cleared.
- R11: AND (9), OR (10) and XOR (11) combine a with b. Complement (12) inverts a, rotate left (13) and rotate right (15) rotate a by one bit, and swap (17) exchanges the two nibbles of a. None of these changes a flag.
- R12: Rotate left through carry (14) writes {a[6:0], carry} and moves a[7] into carry. Rotate right through carry (16) writes {carry, a[7:1]} and moves a[0] into carry.
- R13: `flag_par` is the XOR of the eight bits of the registered primary result, so it is 1 when that value has an odd number of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Perform the operation on this edge |
| op_sel | input | 5 | Operation code from the decoder |
| opnd_a | input | 8 | First operand (accumulator side) |
| opnd_b | input | 8 | Second operand |
| res_lo | output | 8 | Primary result (product low byte, quotient) |
| res_hi | output | 8 | Secondary result (product high byte, remainder) |
| flag_cy | output | 1 | Carry / borrow flag |
| flag_ac | output | 1 | Auxiliary carry from bit 3 |
| flag_ov | output | 1 | Overflow flag |
| flag_par | output | 1 | Parity of the primary result |

## Verification
The flags are the only state the block keeps besides its results, so a wrong carry or auxiliary carry stays hidden until a later operation reads it. The bench therefore chains operations: it sets carry with a compare, then runs add with carry, subtract with borrow, a rotate through carry or a decimal adjust, and the corrupted value shows in the next registered result one cycle later. A wrong result or a flag that should have held appears at the ports on the edge after the operation. Parity is read on every check, so a bad primary result also shows in `flag_par`.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUBB = 5'd2,
        OP_INC  = 5'd3,
        OP_DEC  = 5'd4,
        OP_CMP  = 5'd5,
        OP_MUL  = 5'd6,
        OP_DIV  = 5'd7,
        OP_DADJ = 5'd8,
        OP_AND  = 5'd9,
        OP_OR   = 5'd10,
        OP_XOR  = 5'd11,
        OP_CPL  = 5'd12,
        OP_RL   = 5'd13,
        OP_RLC  = 5'd14,
        OP_RR   = 5'd15,
        OP_RRC  = 5'd16,
        OP_SWAP = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } alu_flags_t;

    // Operations handled by the bitwise/rotate unit
    function automatic logic is_bitwise(alu_op_e op);
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_CPL,
            OP_RL, OP_RLC, OP_RR, OP_RRC, OP_SWAP: return 1'b1;
            default:                               return 1'b0;
        endcase
    endfunction

    // Operations handled by the shared adder
    function automatic logic is_addsub(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             acout,
    output logic             ovout
);
    localparam int NIB = WIDTH / 2;

    logic [WIDTH-1:0] b_eff;
    logic             c_eff;
    logic [NIB:0]     low_part;
    logic [WIDTH-NIB:0] high_part;

    // Subtraction as a + ~b + ~borrow; borrows are inverted carries
    always_comb begin
        b_eff     = sub ? ~b : b;
        c_eff     = sub ? ~cin : cin;
        low_part  = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
        high_part = {1'b0, a[WIDTH-1:NIB]} + {1'b0, b_eff[WIDTH-1:NIB]}
                  + {{(WIDTH-NIB){1'b0}}, low_part[NIB]};
        sum       = {high_part[WIDTH-NIB-1:0], low_part[NIB-1:0]};
        cout      = sub ? ~high_part[WIDTH-NIB] : high_part[WIDTH-NIB];
        acout     = sub ? ~low_part[NIB] : low_part[NIB];
        ovout     = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end

endmodule

// File: rtl/alu_divider.sv
`timescale 1ns/1ps
module alu_divider #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quot,
    output logic [WIDTH-1:0] rem
);
    logic [WIDTH:0] part;
    logic [WIDTH:0] trial;

    // Restoring division, one compare-subtract per quotient bit.
    // A zero divisor never borrows: quotient all ones, remainder = dividend.
    always_comb begin
        part  = '0;
        trial = '0;
        quot  = '0;
        for (int k = WIDTH - 1; k >= 0; k--) begin
            part  = {part[WIDTH-1:0], dividend[k]};
            trial = part - {1'b0, divisor};
            if (!trial[WIDTH]) begin
                part    = trial;
                quot[k] = 1'b1;
            end
        end
        rem = part[WIDTH-1:0];
    end

endmodule

// File: rtl/alu_decadj.sv
`timescale 1ns/1ps
module alu_decadj #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             cy_in,
    input  logic             ac_in,
    output logic [WIDTH-1:0] res,
    output logic             cy_out
);
    localparam int NIB = WIDTH / 2;
    localparam logic [WIDTH:0] LO_FIX = (WIDTH+1)'(6);
    localparam logic [WIDTH:0] HI_FIX = (WIDTH+1)'(6 << NIB);
    localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);

    logic           need_lo, need_hi;
    logic [WIDTH:0] step1, step2;
    logic [WIDTH-1:0] mid;

    always_comb begin
        need_lo = (a[NIB-1:0] > DIGIT_MAX) || ac_in;
        step1   = {1'b0, a} + (need_lo ? LO_FIX : '0);
        mid     = step1[WIDTH-1:0];
        need_hi = (mid[WIDTH-1:NIB] > DIGIT_MAX) || cy_in || step1[WIDTH];
        step2   = {1'b0, mid} + (need_hi ? HI_FIX : '0);
        res     = step2[WIDTH-1:0];
        cy_out  = cy_in | step1[WIDTH] | step2[WIDTH];
    end

endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cy_in,
    output logic [WIDTH-1:0] res,
    output logic             cy_out
);
    localparam int NIB = WIDTH / 2;

    always_comb begin
        res    = a;
        cy_out = cy_in;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CPL:  res = ~a;
            OP_RL:   res = {a[WIDTH-2:0], a[WIDTH-1]};
            OP_RR:   res = {a[0], a[WIDTH-1:1]};
            OP_RLC: begin
                res    = {a[WIDTH-2:0], cy_in};
                cy_out = a[WIDTH-1];
            end
            OP_RRC: begin
                res    = {cy_in, a[WIDTH-1:1]};
                cy_out = a[0];
            end
            OP_SWAP: res = {a[NIB-1:0], a[WIDTH-1:NIB]};
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] res_lo,
    output logic [WIDTH-1:0] res_hi,
    output logic             flag_cy,
    output logic             flag_ac,
    output logic             flag_ov,
    output logic             flag_par
);
    localparam int PW = 2 * WIDTH;

    alu_op_e    op;
    alu_flags_t fl_q, fl_d;
    logic [WIDTH-1:0] lo_q, hi_q, lo_d, hi_d;

    logic [WIDTH-1:0] as_sum, dv_quot, dv_rem, da_res, lg_res;
    logic             as_cy, as_ac, as_ov, da_cy, lg_cy;
    logic [PW-1:0]    prod;

    assign op = alu_op_e'(op_sel);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a     (opnd_a),
        .b     (opnd_b),
        .cin   ((op == OP_ADD) ? 1'b0 : fl_q.cy),
        .sub   (op == OP_SUBB),
        .sum   (as_sum),
        .cout  (as_cy),
        .acout (as_ac),
        .ovout (as_ov)
    );

    alu_divider #(.WIDTH(WIDTH)) u_div (
        .dividend (opnd_a),
        .divisor  (opnd_b),
        .quot     (dv_quot),
        .rem      (dv_rem)
    );

    alu_decadj #(.WIDTH(WIDTH)) u_dadj (
        .a      (opnd_a),
        .cy_in  (fl_q.cy),
        .ac_in  (fl_q.ac),
        .res    (da_res),
        .cy_out (da_cy)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op     (op),
        .a      (opnd_a),
        .b      (opnd_b),
        .cy_in  (fl_q.cy),
        .res    (lg_res),
        .cy_out (lg_cy)
    );

    assign prod = PW'(opnd_a) * PW'(opnd_b);

    // Next-state selection; unlisted codes hold everything
    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        fl_d = fl_q;
        if (is_addsub(op)) begin
            lo_d    = as_sum;
            fl_d.cy = as_cy;
            fl_d.ac = as_ac;
            fl_d.ov = as_ov;
        end else if (is_bitwise(op)) begin
            lo_d    = lg_res;
            fl_d.cy = lg_cy;
        end else begin
            case (op)
                OP_INC: lo_d = opnd_a + WIDTH'(1);
                OP_DEC: lo_d = opnd_a - WIDTH'(1);
                OP_CMP: fl_d.cy = (opnd_a < opnd_b);
                OP_MUL: begin
                    lo_d    = prod[WIDTH-1:0];
                    hi_d    = prod[PW-1:WIDTH];
                    fl_d.cy = 1'b0;
                    fl_d.ov = |prod[PW-1:WIDTH];
                end
                OP_DIV: begin
                    lo_d    = dv_quot;
                    hi_d    = dv_rem;
                    fl_d.cy = 1'b0;
                    fl_d.ov = (opnd_b == '0);
                end
                OP_DADJ: begin
                    lo_d    = da_res;
                    fl_d.cy = da_cy;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
            fl_q <= '0;
        end else if (op_valid) begin
            lo_q <= lo_d;
            hi_q <= hi_d;
            fl_q <= fl_d;
        end
    end

    assign res_lo   = lo_q;
    assign res_hi   = hi_q;
    assign flag_cy  = fl_q.cy;
    assign flag_ac  = fl_q.ac;
    assign flag_ov  = fl_q.ov;
    assign flag_par = ^lo_q;

endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [OP_W-1:0]  op_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] res_lo,
    input logic [WIDTH-1:0] res_hi,
    input logic             flag_cy,
    input logic             flag_ac,
    input logic             flag_ov,
    input logic             flag_par
);
    localparam int PW = 2 * WIDTH;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (res_lo == '0) && (res_hi == '0) && !flag_cy && !flag_ac && !flag_ov);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(res_lo) && $stable(res_hi)
                      && $stable(flag_cy) && $stable(flag_ac) && $stable(flag_ov));

    p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_ADD) |=>
            {flag_cy, res_lo} == ((WIDTH+1)'($past(opnd_a)) + (WIDTH+1)'($past(opnd_b))));

    p_incdec_flags_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_INC || op_sel == OP_DEC)) |=>
            $stable(flag_cy) && $stable(flag_ac) && $stable(flag_ov));

    p_cmp_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_CMP) |=>
            $stable(res_lo) && $stable(res_hi) && (flag_cy == ($past(opnd_a) < $past(opnd_b))));

    p_mul_product_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_MUL) |=>
            !flag_cy && (flag_ov == (res_hi != '0))
            && ({res_hi, res_lo} == (PW'($past(opnd_a)) * PW'($past(opnd_b)))));

    p_div_identity_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_DIV && opnd_b != '0) |=>
            !flag_cy && !flag_ov && (res_hi < $past(opnd_b))
            && ((PW'(res_lo) * PW'($past(opnd_b)) + PW'(res_hi)) == PW'($past(opnd_a))));

    p_div_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_DIV && opnd_b == '0) |=> flag_ov && !flag_cy);

    p_bitwise_flags_r11: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR
                      || op_sel == OP_CPL || op_sel == OP_SWAP)) |=>
            $stable(flag_cy) && $stable(flag_ac) && $stable(flag_ov));

    p_rlc_carry_r12: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_RLC) |=>
            (flag_cy == $past(opnd_a[WIDTH-1])) && (res_lo[0] == $past(flag_cy)));

endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
    import alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [7:0] res_lo, res_hi;
    logic       flag_cy, flag_ac, flag_ov, flag_par;

    int n_chk = 0;
    int n_err = 0;

    // reference state
    int m_lo = 0, m_hi = 0, m_cy = 0, m_ac = 0, m_ov = 0;

    always #2.5 clk = ~clk;

    acc_alu dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_lo(res_lo), .res_hi(res_hi),
        .flag_cy(flag_cy), .flag_ac(flag_ac), .flag_ov(flag_ov), .flag_par(flag_par)
    );

    localparam int NVEC = 32;
    localparam logic [20:0] VEC [0:NVEC-1] = '{
        {5'd0,  8'h3A, 8'h47}, {5'd0,  8'h80, 8'h80}, {5'd1,  8'h0F, 8'h01},
        {5'd1,  8'hF0, 8'h0F}, {5'd2,  8'h50, 8'h60}, {5'd2,  8'h7F, 8'hFF},
        {5'd2,  8'h33, 8'h22}, {5'd3,  8'h7F, 8'h00}, {5'd4,  8'h80, 8'h00},
        {5'd5,  8'h10, 8'h20}, {5'd5,  8'h20, 8'h20}, {5'd6,  8'hFF, 8'hFF},
        {5'd6,  8'h0F, 8'h11}, {5'd7,  8'hFF, 8'h10}, {5'd7,  8'h03, 8'h09},
        {5'd7,  8'hA5, 8'h00}, {5'd0,  8'h29, 8'h38}, {5'd8,  8'h61, 8'h00},
        {5'd0,  8'h99, 8'h99}, {5'd8,  8'h32, 8'h00}, {5'd9,  8'hC3, 8'h5A},
        {5'd10, 8'hC3, 8'h5A}, {5'd11, 8'hC3, 8'h5A}, {5'd12, 8'h0F, 8'h00},
        {5'd13, 8'hA5, 8'h00}, {5'd14, 8'h55, 8'h00}, {5'd15, 8'h5A, 8'h00},
        {5'd16, 8'hAB, 8'h00}, {5'd17, 8'hE1, 8'h00}, {5'd21, 8'h12, 8'h34},
        {5'd2,  8'h00, 8'h00}, {5'd14, 8'hFF, 8'h00}
    };

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic int par_of(int v);
        int p = 0;
        for (int i = 0; i < 8; i++) p = p ^ ((v >> i) & 1);
        return p;
    endfunction

    function automatic string req_of(int op);
        case (op)
            0, 1:   return "R3";
            2:      return "R4";
            3, 4:   return "R5";
            5:      return "R6";
            6:      return "R7";
            7:      return "R8";
            8:      return "R10";
            14, 16: return "R12";
            9, 10, 11, 12, 13, 15, 17: return "R11";
            default: return "R2";
        endcase
    endfunction

    // Independent behavioural model of one operation
    task automatic model_step(input int op, input int a, input int b);
        int s, c;
        case (op)
            0, 1: begin
                c = (op == 1) ? m_cy : 0;
                s = a + b + c;
                m_ac = (((a & 15) + (b & 15) + c) > 15) ? 1 : 0;
                m_ov = ((sgn(a) + sgn(b) + c) > 127 || (sgn(a) + sgn(b) + c) < -128) ? 1 : 0;
                m_cy = (s > 255) ? 1 : 0;
                m_lo = s & 255;
            end
            2: begin
                c = m_cy;
                s = a - b - c;
                m_ac = (((a & 15) - (b & 15) - c) < 0) ? 1 : 0;
                m_ov = ((sgn(a) - sgn(b) - c) > 127 || (sgn(a) - sgn(b) - c) < -128) ? 1 : 0;
                m_cy = (s < 0) ? 1 : 0;
                m_lo = s & 255;
            end
            3: m_lo = (a + 1) & 255;
            4: m_lo = (a + 255) & 255;
            5: m_cy = (a < b) ? 1 : 0;
            6: begin
                m_lo = (a * b) & 255;
                m_hi = (a * b) >> 8;
                m_ov = (m_hi != 0) ? 1 : 0;
                m_cy = 0;
            end
            7: begin
                m_cy = 0;
                if (b == 0) begin
                    m_lo = 255; m_hi = a; m_ov = 1;
                end else begin
                    m_lo = a / b; m_hi = a % b; m_ov = 0;
                end
            end
            8: begin
                s = a;
                if ((s & 15) > 9 || m_ac == 1) s = s + 6;
                if (s > 255) m_cy = 1;
                s = s & 255;
                if ((s >> 4) > 9 || m_cy == 1) s = s + 96;
                if (s > 255) m_cy = 1;
                m_lo = s & 255;
            end
            9:  m_lo = a & b;
            10: m_lo = a | b;
            11: m_lo = a ^ b;
            12: m_lo = 255 - a;
            13: m_lo = ((a << 1) & 255) | (a >> 7);
            14: begin m_lo = ((a << 1) & 255) | m_cy; m_cy = a >> 7; end
            15: m_lo = (a >> 1) | ((a & 1) << 7);
            16: begin m_lo = (a >> 1) | (m_cy << 7); m_cy = a & 1; end
            17: m_lo = ((a & 15) << 4) | (a >> 4);
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input int op, input int a, input int b);
        @(negedge clk);
        op_sel   = 5'(op);
        opnd_a   = 8'(a);
        opnd_b   = 8'(b);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        model_step(op, a, b);
    endtask

    task automatic match_model(input string req);
        chk(req, "res_lo", int'(res_lo), m_lo);
        chk(req, "res_hi", int'(res_hi), m_hi);
        chk(req, "cy", int'(flag_cy), m_cy);
        chk(req, "ac", int'(flag_ac), m_ac);
        chk(req, "ov", int'(flag_ov), m_ov);
        chk("R13", "par", int'(flag_par), par_of(m_lo));
    endtask

    initial begin
        #(5.0 * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "res_lo", int'(res_lo), 0);
        chk("R1", "res_hi", int'(res_hi), 0);
        chk("R1", "flags", int'({flag_cy, flag_ac, flag_ov}), 0);

        // R2: inputs without op_valid change nothing
        op_sel = 5'd0; opnd_a = 8'h05; opnd_b = 8'h05;
        repeat (2) @(negedge clk);
        chk("R2", "idle res_lo", int'(res_lo), 0);

        // R3: add, signed overflow and aux carry
        do_op(0, 8'h7F, 8'h01);
        chk("R3", "res_lo", int'(res_lo), 8'h80);
        chk("R3", "cy/ac/ov", int'({flag_cy, flag_ac, flag_ov}), 3'b011);
        chk("R13", "par", int'(flag_par), 1);
        do_op(0, 8'hFF, 8'h01);
        chk("R3", "res_lo", int'(res_lo), 8'h00);
        chk("R3", "cy/ac/ov", int'({flag_cy, flag_ac, flag_ov}), 3'b110);
        do_op(1, 8'h10, 8'h20);
        chk("R3", "addc res_lo", int'(res_lo), 8'h31);
        chk("R3", "addc cy", int'(flag_cy), 0);

        // R6 then R4
        do_op(5, 8'h05, 8'h01);
        chk("R6", "cmp cy", int'(flag_cy), 0);
        chk("R6", "cmp res_lo held", int'(res_lo), 8'h31);
        do_op(2, 8'h80, 8'h01);
        chk("R4", "subb res_lo", int'(res_lo), 8'h7F);
        chk("R4", "cy/ac/ov", int'({flag_cy, flag_ac, flag_ov}), 3'b011);
        do_op(5, 8'h01, 8'h05);
        chk("R6", "cmp cy", int'(flag_cy), 1);
        chk("R6", "cmp res_lo held", int'(res_lo), 8'h7F);
        do_op(2, 8'h10, 8'h01);
        chk("R4", "subb borrow in", int'(res_lo), 8'h0E);
        chk("R4", "cy/ac/ov", int'({flag_cy, flag_ac, flag_ov}), 3'b010);

        // R5: wrap, flags held (cy0 ac1 ov0)
        do_op(3, 8'hFF, 8'h00);
        chk("R5", "inc wrap", int'(res_lo), 8'h00);
        chk("R5", "flags held", int'({flag_cy, flag_ac, flag_ov}), 3'b010);
        do_op(4, 8'h00, 8'h00);
        chk("R5", "dec wrap", int'(res_lo), 8'hFF);
        chk("R5", "flags held", int'({flag_cy, flag_ac, flag_ov}), 3'b010);

        // R7 multiply
        do_op(6, 8'h80, 8'h02);
        chk("R7", "lo/hi", int'({res_hi, res_lo}), 16'h0100);
        chk("R7", "cy/ov", int'({flag_cy, flag_ov}), 2'b01);
        do_op(6, 12, 10);
        chk("R7", "lo/hi", int'({res_hi, res_lo}), 16'h0078);
        chk("R7", "ov", int'(flag_ov), 0);

        // R8 / R9 divide
        do_op(7, 200, 7);
        chk("R8", "quot/rem", int'({res_hi, res_lo}), 16'h041C);
        chk("R8", "cy/ov", int'({flag_cy, flag_ov}), 0);
        do_op(7, 5, 0);
        chk("R9", "quot/rem", int'({res_hi, res_lo}), 16'h05FF);
        chk("R9", "cy/ov", int'({flag_cy, flag_ov}), 2'b01);

        // R10 decimal adjust
        do_op(0, 8'h08, 8'h08);
        do_op(8, 8'h10, 8'h00);
        chk("R10", "ac-driven low fix", int'(res_lo), 8'h16);
        chk("R10", "cy", int'(flag_cy), 0);
        do_op(0, 8'h01, 8'h01);
        do_op(8, 8'h9A, 8'h00);
        chk("R10", "both fixes", int'(res_lo), 8'h00);
        chk("R10", "cy set", int'(flag_cy), 1);
        do_op(8, 8'h23, 8'h00);
        chk("R10", "cy-driven high fix", int'(res_lo), 8'h83);
        chk("R10", "cy kept", int'(flag_cy), 1);

        // R12 rotates through carry
        do_op(16, 8'h02, 8'h00);
        chk("R12", "rrc res", int'(res_lo), 8'h81);
        chk("R12", "rrc cy", int'(flag_cy), 0);
        do_op(14, 8'h80, 8'h00);
        chk("R12", "rlc res", int'(res_lo), 8'h00);
        chk("R12", "rlc cy", int'(flag_cy), 1);

        // R11 bitwise group, flags held
        do_op(17, 8'h12, 8'h00);
        chk("R11", "swap", int'(res_lo), 8'h21);
        do_op(13, 8'h81, 8'h00);
        chk("R11", "rl", int'(res_lo), 8'h03);
        do_op(12, 8'h55, 8'h00);
        chk("R11", "cpl", int'(res_lo), 8'hAA);
        chk("R11", "cy held", int'(flag_cy), 1);

        // R2: unused code
        do_op(31, 8'h77, 8'h11);
        chk("R2", "unused code res_lo", int'(res_lo), 8'hAA);
        chk("R2", "unused code cy", int'(flag_cy), 1);

        // whole-state check against the model, then table walk
        match_model("R2");
        for (int i = 0; i < NVEC; i++) begin
            do_op(int'(VEC[i][20:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));
            match_model(req_of(int'(VEC[i][20:16])));
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule